// File: doc/BRIEF.md
# Relay Ensemble Early-Stop Controller

This block is the outer loop around a belief-propagation decoder core that runs a relay schedule. A decode is split into legs. At the start of every leg the controller hands the core a fresh set of biased priors. Each biased prior blends the node's channel prior with the belief that node reached at the end of the previous leg. The blend weight is a signed per-node strength, taken from the row of a strength table that the leg index selects. Beliefs are never reset between legs: leg 0 starts from the priors, and every later leg starts from where the previous leg stopped.

The core reports one iteration per strobe. Each strobe carries the unsatisfied-check vector, the hard-decision vector and the current beliefs. The controller counts the failing checks on every strobe. A leg ends in one of three ways: the syndrome clears, the failing-check count has not improved for a patience window, or the iteration cap for the leg is reached. Every converged attempt is offered to a keep-best register, which holds the lowest-weight hard decision seen. Decoding finishes as soon as the required number of converged solutions has been collected, or when the last leg ends. A single-cycle done pulse then presents whether any solution exists, together with the best vector.

The control is a four-state machine. IDLE waits for `start_i` (the IDLE to LAUNCH transition). LAUNCH lasts one cycle, pulses `leg_start_o` and moves to RUN. RUN consumes strobes and has two exits: "leg over" goes back to LAUNCH with the next leg, and "decode over" goes to FINISH. FINISH pulses `done_o` and returns to IDLE.

Top module: `relay_stop_ctrl`

## Requirements
- R1: After reset `leg_start_o`, `done_o`, `found_o` and `best_o` are all 0. A `start_i` pulse sampled in IDLE raises `leg_start_o` for exactly one cycle, on the next cycle, with `leg_o`=0 and `bias_o` equal to the priors, because the beliefs begin equal to the priors.
- R2: For an unpinned node, the biased prior is prior + ((s × (belief − prior)) >>> SHIFT). Here s is the signed two's-complement strength, the product is signed, the shift is arithmetic (it rounds toward minus infinity), and the result saturates to the signed LLR_W range. Node n occupies bits [n*LLR_W +: LLR_W] of `bias_o`, `prior_i` and `belief_i`.
- R3: A node whose bit in `pin_i` (captured at start) is 1 gets its prior on `bias_o` unchanged, whatever its strength and belief.
- R4: The belief used at the start of leg k>0 is the `belief_i` of the last iteration of leg k−1.
- R5: A write with `tbl_we_i`=1 stores `tbl_data_i` as the strength of node `tbl_node_i` in leg row `tbl_leg_i`. Leg k uses row k.
- R6: The failing-check count is the popcount of `syndrome_i`. An iteration improves when it is the first of its leg or when its count is strictly below the best count so far in that leg. The leg ends on the iteration that makes PATIENCE consecutive non-improving iterations.
- R7: A leg ends after MAX_ITER iterations even if it is still improving.
- R8: An iteration with a count of zero ends the leg as converged. Once SOLS_NEEDED converged legs exist, decoding ends at once: `done_o` rises the cycle after that strobe, and no further leg starts.
- R9: A converged attempt replaces the stored best when none is stored yet or when the popcount of its `hard_i` is strictly smaller. On equal weight the earlier attempt is kept.
- R10: When the leg with index N_LEGS−1 ends without the decode having finished earlier, `done_o` pulses. `found_o` is 1 only if some leg converged. `best_o` is 0 when none did.
- R11: `iter_valid_i` strobes outside RUN (in IDLE or LAUNCH) are ignored. They start nothing and cause no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-decode pulse, honoured in IDLE |
| prior_i | input | N_NODES*LLR_W | Channel priors, captured at start |
| pin_i | input | N_NODES | Pinned-node mask, captured at start |
| tbl_we_i | input | 1 | Strength table write enable |
| tbl_leg_i | input | LEG_W | Table row (leg) to write |
| tbl_node_i | input | NODE_W | Table column (node) to write |
| tbl_data_i | input | STR_W | Signed strength to store |
| iter_valid_i | input | 1 | Iteration strobe from the core |
| syndrome_i | input | N_CHECKS | Unsatisfied-check vector |
| hard_i | input | N_NODES | Hard-decision vector |
| belief_i | input | N_NODES*LLR_W | Current beliefs |
| leg_start_o | output | 1 | One-cycle pulse: core loads `bias_o` |
| leg_o | output | LEG_W | Current leg index |
| bias_o | output | N_NODES*LLR_W | Biased priors for the current leg |
| done_o | output | 1 | One-cycle decode-finished pulse |
| found_o | output | 1 | A converged solution exists |
| best_o | output | N_NODES | Best converged hard decision |

## Verification
The bench runs scripts that end legs in each of the three ways. It times every leg-start and done event to the exact cycle. A controller whose stall counter does not clear on improvement, or that counts the first iteration as a stall, would relaunch a leg early, so the event would be early. One that treats an equal count as an improvement would run the leg long. Leg-start biases are compared against an independent evaluation of the blend. The stimulus mixes negative strengths, negative differences that exercise the floor-rounding shift, and extreme priors that saturate. A design that reset beliefs between legs, or that read the wrong table row, would produce biases that differ from the expected ones. A rewritten table entry checks the write port. The keep-best rule is probed with a strictly lighter second solution and with an equal-weight one, and a wrong tie rule would report the later vector. A run with no convergence must report found=0. Strobes while the controller is idle must produce nothing.

// File: rtl/relay_pkg.sv
package relay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } relay_state_e;

endpackage

// File: rtl/rly_popcount.sv
module rly_popcount #(
    parameter  int W  = 6,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/rly_strength_table.sv
module rly_strength_table #(
    parameter  int N_LEGS  = 4,
    parameter  int N_NODES = 4,
    parameter  int STR_W   = 6,
    localparam int LEG_W   = $clog2(N_LEGS),
    localparam int NODE_W  = $clog2(N_NODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [LEG_W-1:0]         wr_leg,
    input  logic [NODE_W-1:0]        wr_node,
    input  logic [STR_W-1:0]         wr_data,
    input  logic [LEG_W-1:0]         rd_leg,
    output logic [N_NODES*STR_W-1:0] rd_row
);

    logic [STR_W-1:0] mem [N_LEGS][N_NODES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < N_LEGS; l++) begin
                for (int n = 0; n < N_NODES; n++) begin
                    mem[l][n] <= '0;
                end
            end
        end else if (we) begin
            mem[wr_leg][wr_node] <= wr_data;
        end
    end

    always_comb begin
        for (int n = 0; n < N_NODES; n++) begin
            rd_row[n*STR_W +: STR_W] = mem[rd_leg][n];
        end
    end

endmodule

// File: rtl/rly_bias_unit.sv
module rly_bias_unit #(
    parameter int LLR_W = 8,
    parameter int STR_W = 6,
    parameter int SHIFT = 3
) (
    input  logic [LLR_W-1:0] prior,
    input  logic [LLR_W-1:0] belief,
    input  logic [STR_W-1:0] strength,
    input  logic             pinned,
    output logic [LLR_W-1:0] bias
);

    localparam int DW = LLR_W + 1;
    localparam int PW = DW + STR_W;
    localparam int SW = PW + 1;

    localparam logic signed [SW-1:0] MAXV = {{(SW-LLR_W+1){1'b0}}, {(LLR_W-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-LLR_W+1){1'b1}}, {(LLR_W-1){1'b0}}};

    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] diff_x;
    logic signed [PW-1:0] str_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [SW-1:0] sum;

    always_comb begin
        diff   = $signed({belief[LLR_W-1], belief}) - $signed({prior[LLR_W-1], prior});
        diff_x = $signed({{(PW-DW){diff[DW-1]}}, diff});
        str_x  = $signed({{(PW-STR_W){strength[STR_W-1]}}, strength});
        prod   = diff_x * str_x;
        scaled = prod >>> SHIFT;
        sum    = $signed({scaled[PW-1], scaled}) +
                 $signed({{(SW-LLR_W){prior[LLR_W-1]}}, prior});
        if (pinned) begin
            bias = prior;
        end else if (sum > MAXV) begin
            bias = MAXV[LLR_W-1:0];
        end else if (sum < MINV) begin
            bias = MINV[LLR_W-1:0];
        end else begin
            bias = sum[LLR_W-1:0];
        end
    end

endmodule

// File: rtl/relay_stop_ctrl.sv
module relay_stop_ctrl
    import relay_pkg::*;
#(
    parameter  int N_NODES     = 4,
    parameter  int N_CHECKS    = 6,
    parameter  int LLR_W       = 8,
    parameter  int STR_W       = 6,
    parameter  int SHIFT       = 3,
    parameter  int N_LEGS      = 4,
    parameter  int MAX_ITER    = 8,
    parameter  int PATIENCE    = 3,
    parameter  int SOLS_NEEDED = 2,
    localparam int LEG_W       = $clog2(N_LEGS),
    localparam int NODE_W      = $clog2(N_NODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [N_NODES*LLR_W-1:0] prior_i,
    input  logic [N_NODES-1:0]       pin_i,
    input  logic                     tbl_we_i,
    input  logic [LEG_W-1:0]         tbl_leg_i,
    input  logic [NODE_W-1:0]        tbl_node_i,
    input  logic [STR_W-1:0]         tbl_data_i,
    input  logic                     iter_valid_i,
    input  logic [N_CHECKS-1:0]      syndrome_i,
    input  logic [N_NODES-1:0]       hard_i,
    input  logic [N_NODES*LLR_W-1:0] belief_i,
    output logic                     leg_start_o,
    output logic [LEG_W-1:0]         leg_o,
    output logic [N_NODES*LLR_W-1:0] bias_o,
    output logic                     done_o,
    output logic                     found_o,
    output logic [N_NODES-1:0]       best_o
);

    localparam int CW    = $clog2(N_CHECKS + 1);
    localparam int HW    = $clog2(N_NODES + 1);
    localparam int IT_W  = $clog2(MAX_ITER + 1);
    localparam int ST_W  = $clog2(PATIENCE + 1);
    localparam int SOL_W = $clog2(SOLS_NEEDED + 1);

    relay_state_e state_q, state_d;

    logic [LEG_W-1:0]         leg_q;
    logic [IT_W-1:0]          iter_q;
    logic [ST_W-1:0]          stall_q;
    logic [CW-1:0]            legbest_q;
    logic                     leg_first_q;
    logic [SOL_W-1:0]         sols_q;
    logic                     found_q;
    logic [N_NODES-1:0]       best_q;
    logic [HW-1:0]            best_w_q;
    logic [N_NODES*LLR_W-1:0] prior_q;
    logic [N_NODES*LLR_W-1:0] belief_q;
    logic [N_NODES-1:0]       pin_q;

    logic [N_NODES*STR_W-1:0] str_row;
    logic [CW-1:0]            fail_cnt;
    logic [HW-1:0]            hard_w;

    logic             it_fire;
    logic             conv;
    logic             improve;
    logic [ST_W-1:0]  stall_nx;
    logic             hit_stall;
    logic             hit_cap;
    logic [SOL_W-1:0] sols_nx;
    logic             enough;
    logic             last_leg;
    logic             leg_end;
    logic             finish;
    logic             take;

    // ---------------- sub-blocks ----------------
    rly_strength_table #(
        .N_LEGS (N_LEGS),
        .N_NODES(N_NODES),
        .STR_W  (STR_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we_i),
        .wr_leg (tbl_leg_i),
        .wr_node(tbl_node_i),
        .wr_data(tbl_data_i),
        .rd_leg (leg_q),
        .rd_row (str_row)
    );

    rly_popcount #(.W(N_CHECKS)) u_fail_pop (
        .vec(syndrome_i),
        .cnt(fail_cnt)
    );

    rly_popcount #(.W(N_NODES)) u_hard_pop (
        .vec(hard_i),
        .cnt(hard_w)
    );

    for (genvar g = 0; g < N_NODES; g++) begin : g_node
        rly_bias_unit #(
            .LLR_W(LLR_W),
            .STR_W(STR_W),
            .SHIFT(SHIFT)
        ) u_bias (
            .prior   (prior_q[g*LLR_W +: LLR_W]),
            .belief  (belief_q[g*LLR_W +: LLR_W]),
            .strength(str_row[g*STR_W +: STR_W]),
            .pinned  (pin_q[g]),
            .bias    (bias_o[g*LLR_W +: LLR_W])
        );

        // R3: a pinned node sees its captured prior on the bias bus
        p_pinned_passthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q != ST_IDLE && pin_q[g]) |->
                (bias_o[g*LLR_W +: LLR_W] == prior_q[g*LLR_W +: LLR_W]));
    end

    // ---------------- per-iteration decisions ----------------
    always_comb begin
        it_fire   = (state_q == ST_RUN) && iter_valid_i;
        conv      = (fail_cnt == '0);
        improve   = leg_first_q || (fail_cnt < legbest_q);
        stall_nx  = improve ? '0 : (stall_q + ST_W'(1));
        hit_stall = (stall_nx == ST_W'(PATIENCE));
        hit_cap   = (iter_q == IT_W'(MAX_ITER - 1));
        sols_nx   = sols_q + SOL_W'(conv);
        enough    = conv && (sols_nx == SOL_W'(SOLS_NEEDED));
        last_leg  = (leg_q == LEG_W'(N_LEGS - 1));
        leg_end   = conv || hit_stall || hit_cap;
        finish    = enough || (leg_end && last_leg);
        take      = conv && (!found_q || (hard_w < best_w_q));
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_RUN;
            ST_RUN: begin
                if (it_fire && finish) begin
                    state_d = ST_FINISH;
                end else if (it_fire && leg_end) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        leg_start_o = (state_q == ST_LAUNCH);
        done_o      = (state_q == ST_FINISH);
        leg_o       = leg_q;
        found_o     = found_q;
        best_o      = best_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leg_q       <= '0;
            iter_q      <= '0;
            stall_q     <= '0;
            legbest_q   <= '0;
            leg_first_q <= 1'b1;
            sols_q      <= '0;
            found_q     <= 1'b0;
            best_q      <= '0;
            best_w_q    <= '0;
            prior_q     <= '0;
            belief_q    <= '0;
            pin_q       <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            leg_q       <= '0;
            iter_q      <= '0;
            stall_q     <= '0;
            legbest_q   <= '0;
            leg_first_q <= 1'b1;
            sols_q      <= '0;
            found_q     <= 1'b0;
            best_q      <= '0;
            best_w_q    <= '0;
            prior_q     <= prior_i;
            belief_q    <= prior_i;
            pin_q       <= pin_i;
        end else if (it_fire) begin
            belief_q <= belief_i;
            sols_q   <= sols_nx;
            if (take) begin
                found_q  <= 1'b1;
                best_q   <= hard_i;
                best_w_q <= hard_w;
            end
            if (improve) begin
                legbest_q <= fail_cnt;
            end
            if (leg_end) begin
                iter_q      <= '0;
                stall_q     <= '0;
                leg_first_q <= 1'b1;
                if (!finish) begin
                    leg_q <= leg_q + LEG_W'(1);
                end
            end else begin
                iter_q      <= iter_q + IT_W'(1);
                stall_q     <= stall_nx;
                leg_first_q <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    // R1: the leg-start strobe lasts one cycle
    p_launch_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        leg_start_o |=> !leg_start_o);

    // R8: the done strobe lasts one cycle and is followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !leg_start_o));

    // R6: the stall counter never reaches the patience window while running
    p_stall_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (stall_q < ST_W'(PATIENCE)));

    // R7: the per-leg iteration counter stays below the cap
    p_iter_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (iter_q < IT_W'(MAX_ITER)));

    // R9: once a solution is kept its weight never grows within a decode
    p_best_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && state_q != ST_IDLE) |=> (found_q && best_w_q <= $past(best_w_q)));

    // R11: a strobe outside RUN leaves the beliefs untouched
    p_idle_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH && iter_valid_i) |=> $stable(belief_q));

endmodule

// File: tb/relay_stop_ctrl_tb.sv
module relay_stop_ctrl_tb;

    localparam int NN    = 4;
    localparam int NC    = 6;
    localparam int NL    = 4;
    localparam int MAXIT = 8;
    localparam int PAT   = 3;
    localparam int SOLS  = 2;

    typedef struct packed {
        logic        kind;    // 0 = leg start, 1 = done
        logic [31:0] cyc;
        logic [1:0]  leg;
        logic [31:0] bias;
        logic        found;
        logic [3:0]  best;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] prior_i = '0;
    logic [3:0]  pin_i = '0;
    logic        tbl_we_i = 1'b0;
    logic [1:0]  tbl_leg_i = '0;
    logic [1:0]  tbl_node_i = '0;
    logic [5:0]  tbl_data_i = '0;
    logic        iter_valid_i = 1'b0;
    logic [5:0]  syndrome_i = '0;
    logic [3:0]  hard_i = '0;
    logic [31:0] belief_i = '0;
    logic        leg_start_o;
    logic [1:0]  leg_o;
    logic [31:0] bias_o;
    logic        done_o;
    logic        found_o;
    logic [3:0]  best_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   ended   = 0;
    exp_t q[$];

    int   m_prior[NN];
    int   m_bel[NN];
    int   m_str[NL][NN];
    bit   m_pin[NN];

    relay_stop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prior_i(prior_i), .pin_i(pin_i),
        .tbl_we_i(tbl_we_i), .tbl_leg_i(tbl_leg_i), .tbl_node_i(tbl_node_i),
        .tbl_data_i(tbl_data_i), .iter_valid_i(iter_valid_i), .syndrome_i(syndrome_i),
        .hard_i(hard_i), .belief_i(belief_i), .leg_start_o(leg_start_o), .leg_o(leg_o),
        .bias_o(bias_o), .done_o(done_o), .found_o(found_o), .best_o(best_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] calc_bias(input int leg);
        logic [31:0] r;
        int d, p, v;
        r = '0;
        for (int n = 0; n < NN; n++) begin
            if (m_pin[n]) begin
                v = m_prior[n];
            end else begin
                d = m_bel[n] - m_prior[n];
                p = m_str[leg][n] * d;
                v = m_prior[n] + (p >>> 3);
                if (v > 127) v = 127;
                if (v < -128) v = -128;
            end
            r[n*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic int fail_of(input int sc, input int leg, input int it);
        int a0[5] = '{5, 4, 4, 5, 4};
        int a1[8] = '{6, 5, 4, 3, 2, 1, 1, 1};
        if (sc == 0 || sc == 3) begin
            if (leg == 0) return (it == 0) ? 4 : ((it == 1) ? 3 : 0);
            if (leg == 1) return (it == 0) ? 5 : 0;
            return 6;
        end
        if (sc == 1) begin
            if (leg == 0) return a0[it];
            if (leg == 1) return a1[it];
            return 0;
        end
        return 3;
    endfunction

    function automatic logic [3:0] hard_of(input int sc, input int leg, input int it);
        if ((sc == 0 || sc == 3) && leg == 0) return 4'b0111;
        if ((sc == 0 || sc == 3) && leg == 1) return 4'b1000;
        if (sc == 1 && leg == 2) return 4'b0011;
        if (sc == 1 && leg == 3) return 4'b1100;
        return 4'(leg * 5 + it * 3 + 1);
    endfunction

    function automatic int belief_of(input int sc, input int leg, input int it, input int n);
        return ((sc * 17 + leg * 37 + it * 11 + n * 53 + 90) % 256) - 128;
    endfunction

    task automatic wr_tbl(input int l, input int n, input int v);
        @(negedge clk);
        tbl_we_i   = 1'b1;
        tbl_leg_i  = 2'(l);
        tbl_node_i = 2'(n);
        tbl_data_i = 6'(v);
        m_str[l][n] = v;
        @(negedge clk);
        tbl_we_i = 1'b0;
    endtask

    // driver: plays the core and pushes the expected events
    task automatic run_scn(input int sc, input int pr[NN], input logic [3:0] pin);
        int leg, it, f, lbest, stall, sols, bw, hw;
        bit first, conv, improve, legend, fin, found;
        logic [3:0] best, hv;
        exp_t e;
        @(negedge clk);
        for (int n = 0; n < NN; n++) begin
            m_prior[n] = pr[n];
            m_bel[n]   = pr[n];
            m_pin[n]   = pin[n];
            prior_i[n*8 +: 8] = 8'(pr[n]);
        end
        pin_i   = pin;
        start_i = 1'b1;
        e = '0;
        e.cyc  = 32'(cyc + 1);
        e.bias = calc_bias(0);
        q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        leg = 0; sols = 0; found = 0; best = '0; bw = 0; fin = 0;
        while (!fin) begin
            it = 0; stall = 0; lbest = 0; first = 1; legend = 0;
            while (!legend) begin
                @(negedge clk);
                f  = fail_of(sc, leg, it);
                hv = hard_of(sc, leg, it);
                syndrome_i = '0;
                for (int k = 0; k < f; k++) syndrome_i[k] = 1'b1;
                hard_i = hv;
                for (int n = 0; n < NN; n++) begin
                    m_bel[n] = belief_of(sc, leg, it, n);
                    belief_i[n*8 +: 8] = 8'(m_bel[n]);
                end
                iter_valid_i = 1'b1;
                conv    = (f == 0);
                improve = first || (f < lbest);
                stall   = improve ? 0 : stall + 1;
                if (improve) lbest = f;
                first   = 0;
                legend  = conv || (stall == PAT) || (it + 1 == MAXIT);
                if (conv) begin
                    sols++;
                    hw = $countones(hv);
                    if (!found || hw < bw) begin
                        best = hv;
                        bw   = hw;
                    end
                    found = 1;
                end
                if (legend) begin
                    e = '0;
                    e.cyc = 32'(cyc + 1);
                    if ((conv && sols == SOLS) || leg == NL - 1) begin
                        fin     = 1;
                        e.kind  = 1'b1;
                        e.found = found;
                        e.best  = best;
                    end else begin
                        leg++;
                        e.leg  = 2'(leg);
                        e.bias = calc_bias(leg);
                    end
                    q.push_back(e);
                end
                @(negedge clk);
                iter_valid_i = 1'b0;
                it++;
            end
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares every event the design produces
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (leg_start_o || done_o)) begin
            if (q.size() == 0) begin
                check(1'b0, "R6 R8 R11 unexpected event", {30'd0, done_o, leg_start_o}, 32'd0);
            end else begin
                e = q.pop_front();
                check(e.cyc == 32'(cyc), "R6 R7 R8 event cycle", 32'(cyc), e.cyc);
                check(done_o == e.kind, "R8 R10 event kind", {31'd0, done_o}, {31'd0, e.kind});
                if (!e.kind) begin
                    check(leg_o == e.leg, "R5 leg index", {30'd0, leg_o}, {30'd0, e.leg});
                    check(bias_o == e.bias, "R1 R2 R3 R4 R5 leg bias", bias_o, e.bias);
                end else begin
                    check(found_o == e.found, "R10 found flag", {31'd0, found_o}, {31'd0, e.found});
                    check(best_o == e.best, "R9 best vector", {28'd0, best_o}, {28'd0, e.best});
                end
            end
        end
    end

    initial begin
        int pr0[NN] = '{20, -30, 5, 127};
        int pr1[NN] = '{-128, 64, -7, 1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!leg_start_o, "R1 reset leg_start", {31'd0, leg_start_o}, 32'd0);
        check(!done_o, "R1 reset done", {31'd0, done_o}, 32'd0);
        check(!found_o && best_o == '0, "R1 reset found/best", {27'd0, found_o, best_o}, 32'd0);
        // R11: strobes with a clear syndrome while idle do nothing
        syndrome_i = '0;
        hard_i = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            iter_valid_i = 1'b1;
            @(negedge clk);
            check(!done_o && !leg_start_o, "R11 idle strobe ignored",
                  {30'd0, done_o, leg_start_o}, 32'd0);
        end
        iter_valid_i = 1'b0;
        @(negedge clk);
        check(!found_o, "R11 idle strobe left found", {31'd0, found_o}, 32'd0);
        // R5: load the strength table
        for (int l = 0; l < NL; l++) begin
            for (int n = 0; n < NN; n++) begin
                wr_tbl(l, n, ((l * 13 + n * 29 + 5) % 64) - 32);
            end
        end
        run_scn(0, pr0, 4'b0000);   // R8 R9: two converging legs, lighter wins
        run_scn(1, pr1, 4'b1000);   // R6 R7 R9: stall end, cap end, equal-weight tie
        run_scn(2, pr0, 4'b0101);   // R3 R10: pinned nodes, no convergence
        wr_tbl(1, 2, -32);          // R5: rewrite one entry
        wr_tbl(1, 0, 31);
        run_scn(3, pr1, 4'b0000);
        check(q.size() == 0, "R8 R10 missing events", 32'(q.size()), 32'd0);
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R8: actual hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule